// File: doc/BRIEF.md
# Multiphase Parity Sampler with Decimating Output

This block turns a bundle of evenly spread oscillator phases into a stream of bits. Every phase line gets its own flip-flop, and all of them are captured on the same edge of the reference clock. The captured word is folded to one parity bit by a registered XOR tree. The tree has a bounded fan-in per level, so the raw bit rate can follow the clock at any phase count.

A parity decimator follows the tree. It XORs a fixed number of successive raw bits and emits their combined value as one output bit, with a strobe that lasts one cycle. A larger group lowers the output rate and reduces bias. A group size of one passes every raw bit straight through. The consumer sees a plain valid strobe with no ready signal. The source cannot be paused, so each strobed bit must be taken in the cycle it appears. The `enable` input halts the whole path in place.

Top module: `mps_parity_sampler`

## Requirements
- R1: While `rst_n` is low, and until the pipeline has filled after reset, `bit_valid` is 0. `bit_out` resets to 0.
- R2: Each raw bit is the XOR of all `PHASES` inputs, captured together on one clock edge.
- R3: The result depends only on how many phase inputs are 1, not on which positions they occupy. A single 1 on any of the `PHASES` input positions yields a raw bit of 1.
- R4: Counting only cycles with `enable` high, a raw bit captured on edge k reaches the decimator on edge k + D, where D = 1 + (number of tree levels). The tree levels come from dividing `PHASES` by `TREE_FANIN`, rounding up, until one bit remains, with at least one level. The first `bit_valid` follows on edge `D + DECIM_ORDER`.
- R5: `bit_valid` goes high for exactly one cycle after every `DECIM_ORDER` raw bits consumed. When `DECIM_ORDER` > 1 it is never high on two cycles in a row.
- R6: With a strobe, `bit_out` is the XOR of the `DECIM_ORDER` raw bits of that group. The accumulator then clears, so groups do not overlap. Between strobes `bit_out` holds its value.
- R7: With `DECIM_ORDER` = 1, each raw bit appears on `bit_out` with a strobe, one cycle after it reaches the decimator.
- R8: A cycle with `enable` low changes no captured sample, tree register, fill state or group progress, and is followed by `bit_valid` = 0. Grouping resumes where it stopped.
- R9: Asserting reset in the middle of a group discards the partial group and all pipeline contents. The next group starts fresh and obeys R4 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Advances capture, tree, fill state and decimator when high |
| phase_in | input | PHASES | Multiphase oscillator lines, one per flip-flop |
| bit_out | output | 1 | Decimated output bit |
| bit_valid | output | 1 | One-cycle strobe marking a new `bit_out` |

## Verification
The hardest state to reach is a decimation group split by pauses. In that state some raw bits of the group are already in the accumulator, others are still in the tree, and `enable` drops in between. A reset can also land in the middle of such a group. The stimulus toggles `enable` randomly on about one cycle in three, over stretches long enough that many groups straddle a pause. It also asserts reset after a few cycles of a fresh group. A second instance with a small phase count and a group size of one shows each raw parity directly, so the latency and the walking single-one pattern are observed bit by bit.

// File: rtl/mps_pkg.sv
package mps_pkg;

  // Number of registered XOR levels needed to fold n bits with fan-in f.
  function automatic int tree_levels(input int n, input int f);
    int w;
    int lv;
    w  = n;
    lv = 0;
    do begin
      w  = (w + f - 1) / f;
      lv = lv + 1;
    end while (w > 1);
    return lv;
  endfunction

  // Width of the vector entering level k (k = 0 is the captured word).
  function automatic int level_width(input int n, input int f, input int k);
    int w;
    w = n;
    for (int i = 0; i < k; i++) w = (w + f - 1) / f;
    return w;
  endfunction

endpackage

// File: rtl/mps_capture.sv
module mps_capture #(
  parameter int PHASES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PHASES-1:0] phase_i,
  output logic [PHASES-1:0] smp_o
);

  // One flip-flop per phase line, all sharing the same edge.
  for (genvar i = 0; i < PHASES; i++) begin : g_ff
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  smp_o[i] <= 1'b0;
      else if (en) smp_o[i] <= phase_i[i];
    end
  end

endmodule

// File: rtl/mps_xor_tree.sv
module mps_xor_tree
  import mps_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int FANIN = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic             dout
);

  localparam int LEVELS = tree_levels(WIDTH, FANIN);

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int WI = level_width(WIDTH, FANIN, k);
    localparam int WO = level_width(WIDTH, FANIN, k + 1);

    logic [WI-1:0] src;
    logic [WO-1:0] nxt;
    logic [WO-1:0] q;

    if (k == 0) begin : g_src0
      assign src = din;
    end else begin : g_srcn
      assign src = g_lvl[k-1].q;
    end

    always_comb begin
      for (int g = 0; g < WO; g++) begin
        nxt[g] = 1'b0;
        for (int i = 0; i < FANIN; i++) begin
          if (g * FANIN + i < WI) nxt[g] = nxt[g] ^ src[g * FANIN + i];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nxt;
    end
  end

  assign dout = g_lvl[LEVELS-1].q[0];

endmodule

// File: rtl/mps_valid_delay.sv
module mps_valid_delay #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic vld_o
);

  // Fill marker: a 1 walks in on every enabled edge and stays once at the end.
  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sr <= '0;
    else if (en) sr <= {sr[DEPTH-2:0], 1'b1};
  end

  assign vld_o = sr[DEPTH-1];

endmodule

// File: rtl/mps_decimator.sv
module mps_decimator #(
  parameter int ORDER = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic raw_vld,
  input  logic raw_bit,
  output logic out_bit,
  output logic out_vld
);

  if (ORDER == 1) begin : g_pass
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_bit <= 1'b0;
        out_vld <= 1'b0;
      end else begin
        out_vld <= 1'b0;
        if (en && raw_vld) begin
          out_bit <= raw_bit;
          out_vld <= 1'b1;
        end
      end
    end
  end else begin : g_group
    localparam int CW = $clog2(ORDER);
    localparam logic [CW-1:0] LAST = CW'(ORDER - 1);

    logic [CW-1:0] cnt;
    logic          acc;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt     <= '0;
        acc     <= 1'b0;
        out_bit <= 1'b0;
        out_vld <= 1'b0;
      end else begin
        out_vld <= 1'b0;
        if (en && raw_vld) begin
          if (cnt == LAST) begin
            out_bit <= acc ^ raw_bit;
            out_vld <= 1'b1;
            acc     <= 1'b0;
            cnt     <= '0;
          end else begin
            acc <= acc ^ raw_bit;
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/mps_parity_sampler.sv
module mps_parity_sampler
  import mps_pkg::*;
#(
  parameter int PHASES      = 64,
  parameter int DECIM_ORDER = 8,
  parameter int TREE_FANIN  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [PHASES-1:0] phase_in,
  output logic              bit_out,
  output logic              bit_valid
);

  localparam int LEVELS     = tree_levels(PHASES, TREE_FANIN);
  localparam int PIPE_DEPTH = LEVELS + 1;

  logic [PHASES-1:0] smp;
  logic              raw_bit;
  logic              raw_vld;

  mps_capture #(.PHASES(PHASES)) i_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (enable),
    .phase_i (phase_in),
    .smp_o   (smp)
  );

  mps_xor_tree #(.WIDTH(PHASES), .FANIN(TREE_FANIN)) i_tree (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (enable),
    .din   (smp),
    .dout  (raw_bit)
  );

  mps_valid_delay #(.DEPTH(PIPE_DEPTH)) i_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (enable),
    .vld_o (raw_vld)
  );

  mps_decimator #(.ORDER(DECIM_ORDER)) i_decim (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (enable),
    .raw_vld (raw_vld),
    .raw_bit (raw_bit),
    .out_bit (bit_out),
    .out_vld (bit_valid)
  );

endmodule

// File: rtl/mps_parity_sampler_chk.sv
module mps_parity_sampler_chk
  import mps_pkg::*;
#(
  parameter int PHASES      = 64,
  parameter int DECIM_ORDER = 8,
  parameter int TREE_FANIN  = 6
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic bit_out,
  input logic bit_valid,
  input logic raw_valid
);

  localparam int DEPTH = tree_levels(PHASES, TREE_FANIN) + 1;

  int fill_cnt;
  int raw_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= 0;
      raw_cnt  <= 0;
    end else if (enable) begin
      if (fill_cnt <= DEPTH) fill_cnt <= fill_cnt + 1;
      if (raw_valid) raw_cnt <= (raw_cnt == DECIM_ORDER - 1) ? 0 : raw_cnt + 1;
    end
  end

  // R1 / R4: no strobe before the pipeline has filled
  p_no_early_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> fill_cnt > DEPTH);

  // R5: strobe lasts one cycle when groups span several raw bits
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (DECIM_ORDER > 1 && bit_valid) |=> !bit_valid);

  // R5: a strobe lines up with a completed group of raw bits
  p_group_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> raw_cnt == 0);

  // R6: output bit holds between strobes
  p_bit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> $stable(bit_out));

  // R8: a paused cycle yields no strobe
  p_pause_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !bit_valid);

endmodule

bind mps_parity_sampler mps_parity_sampler_chk #(
  .PHASES      (PHASES),
  .DECIM_ORDER (DECIM_ORDER),
  .TREE_FANIN  (TREE_FANIN)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .bit_out   (bit_out),
  .bit_valid (bit_valid),
  .raw_valid (raw_vld)
);

// File: tb/test_mps_parity_sampler.sv
module mps_ref_model #(
  parameter int L     = 64,
  parameter int ORDER = 8,
  parameter int FANIN = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [L-1:0] ph,
  output logic         exp_bit,
  output logic         exp_vld
);

  // Latency from the requirement: one capture edge plus one edge per fold.
  function automatic int lat();
    int w;
    int n;
    w = L;
    n = 0;
    do begin
      w = (w + FANIN - 1) / FANIN;
      n++;
    end while (w > 1);
    return n + 1;
  endfunction

  localparam int D = lat();

  logic q[$];
  int   cnt;
  logic acc;

  initial begin
    exp_bit = 1'b0;
    exp_vld = 1'b0;
    cnt     = 0;
    acc     = 1'b0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      cnt     = 0;
      acc     = 1'b0;
      exp_bit = 1'b0;
      exp_vld = 1'b0;
    end else if (en) begin
      exp_vld = 1'b0;
      if (q.size() >= D) begin
        logic r;
        r   = q.pop_front();
        acc = acc ^ r;
        cnt++;
        if (cnt == ORDER) begin
          exp_bit = acc;
          exp_vld = 1'b1;
          acc     = 1'b0;
          cnt     = 0;
        end
      end
      q.push_back(^ph);
    end else begin
      exp_vld = 1'b0;
    end
  end

endmodule

module test_mps_parity_sampler;

  localparam int LA = 64;
  localparam int OA = 8;
  localparam int LB = 13;
  localparam int OB = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [LA-1:0] ph = '0;
  logic          a_bit, a_vld, b_bit, b_vld;
  logic          ea_bit, ea_vld, eb_bit, eb_vld;
  int            n_run = 0;
  int            n_fail = 0;
  string         req_a = "R1";
  string         req_b = "R1";
  bit            done = 1'b0;

  always #4 clk = ~clk;

  mps_parity_sampler #(.PHASES(LA), .DECIM_ORDER(OA)) i_mps_parity_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (en),
    .phase_in  (ph),
    .bit_out   (a_bit),
    .bit_valid (a_vld)
  );

  mps_parity_sampler #(.PHASES(LB), .DECIM_ORDER(OB)) i_mps_parity_sampler_raw (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (en),
    .phase_in  (ph[LB-1:0]),
    .bit_out   (b_bit),
    .bit_valid (b_vld)
  );

  mps_ref_model #(.L(LA), .ORDER(OA)) i_ref_a (
    .clk(clk), .rst_n(rst_n), .en(en), .ph(ph), .exp_bit(ea_bit), .exp_vld(ea_vld)
  );

  mps_ref_model #(.L(LB), .ORDER(OB)) i_ref_b (
    .clk(clk), .rst_n(rst_n), .en(en), .ph(ph[LB-1:0]), .exp_bit(eb_bit), .exp_vld(eb_vld)
  );

  task automatic cmp(input string req, input string who,
                     input logic gv, input logic gb, input logic ev, input logic eb);
    n_run++;
    if (gv !== ev || gb !== eb) begin
      n_fail++;
      $display("FAIL %s inst %s at %0t: valid/bit got %b/%b expected %b/%b",
               req, who, $time, gv, gb, ev, eb);
    end
  endtask

  // Compare on the falling edge, away from the sampling edge.
  always @(negedge clk) begin
    if (!done) begin
      cmp(req_a, "grouped", a_vld, a_bit, ea_vld, ea_bit);
      cmp(req_b, "raw", b_vld, b_bit, eb_vld, eb_bit);
    end
  end

  task automatic steps(input int n, input bit rand_en);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      ph = {$urandom, $urandom};
      if (rand_en) en = ($urandom % 3) != 0;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1'b1;
    en    = 1'b1;
    // R4: fill latency, first strobes
    req_a = "R4"; req_b = "R4";
    steps(14, 1'b0);
    // R6 / R2: grouped parity and raw parity on random words
    req_a = "R6"; req_b = "R2";
    steps(80, 1'b0);
    // R3: walking single one over every position
    req_a = "R3"; req_b = "R3";
    for (int i = 0; i < LA; i++) begin
      @(negedge clk);
      #1;
      ph = '0;
      ph[i] = 1'b1;
    end
    // R8: random pauses splitting groups
    req_a = "R8"; req_b = "R8";
    steps(120, 1'b1);
    en = 1'b1;
    // R5 / R7: all-ones, all-zeros and random words
    req_a = "R5"; req_b = "R7";
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      #1;
      case (i % 3)
        0:       ph = '1;
        1:       ph = '0;
        default: ph = {$urandom, $urandom};
      endcase
    end
    // R9: reset in the middle of a group
    req_a = "R9"; req_b = "R9";
    steps(5, 1'b0);
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    steps(2, 1'b0);
    @(negedge clk);
    #1;
    rst_n = 1'b1;
    steps(40, 1'b1);
    en = 1'b1;
    steps(20, 1'b0);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule